// File: doc/BRIEF.md
# Restart Marker Position Checker

This block watches the compressed byte stream that enters an image decoder and checks it against the decoder's count of finished minimum coded units (MCUs). The programmed restart interval sets how many MCUs lie between two restart markers. A restart marker is the byte 0xFF followed by one of 0xD0 to 0xD7. The low three bits of the second byte carry a sequence index, and that index steps modulo 8 starting from 0 in each scan. When a marker arrives where the interval says it must, the checker tells the decoder to clear its DC predictors. When a marker is absent, misplaced or not expected at all, it raises one of three separate error pulses.

When the last MCU of an interval completes, the checker opens a short byte window to look for the marker. The window size is a 2-bit setting N and spans N+1 bytes; the surrounding configuration normally holds N at 3. The marker counts as found when its 0xFF byte falls inside the window. A scan-start strobe brings the checker back to its initial state for a new scan.

Top module: `rstmk_checker`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is 0. The first marker expected after reset carries index 0 (byte 0xD0).
- R2: A marker is a valid 0xFF byte followed by a valid byte whose upper five bits are 11010. Repeated 0xFF bytes before the second byte are allowed. Pairs such as 0xFF,0x00 or 0xFF,0xD8 are not markers.
- R3: A marker whose index equals the expected index, arriving at an interval boundary, gives a one-cycle `pred_rst` pulse in the cycle after its second byte. The expected index then advances modulo 8, so 0xD7 is followed by 0xD0.
- R4: A marker detected while `rst_intv` is 0 pulses `err_unexp`.
- R5: A marker detected while `rst_intv` is nonzero and before the interval's last MCU pulses `err_pos`.
- R6: A marker found at a boundary whose index differs from the expected index pulses `err_pos`, and the expected index does not advance.
- R7: After the boundary, the 0xFF of the marker must be among the next `win_sel`+1 valid bytes. If it is not, `err_missing` pulses in the cycle after the first byte past that window.
- R8: A marker whose second byte arrives in the same cycle as the `mcu_done` that completes the interval is accepted as correctly placed.
- R9: Each error output pulses for exactly one cycle. After an error, all further error pulses are suppressed until a correctly placed marker or a scan start.
- R10: `scan_start` resets the MCU count, the expected index (back to 0) and the error suppression. No output pulses in the cycle after it.
- R11: An `mcu_done` that arrives while the window search is open has no effect on the search or on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Strobe at the start of each scan |
| byte_vld | input | 1 | `byte_data` holds a stream byte this cycle |
| byte_data | input | 8 | Compressed stream byte |
| mcu_done | input | 1 | Strobe: one MCU finished decoding |
| rst_intv | input | 16 | Restart interval in MCUs, 0 = restarts disabled |
| win_sel | input | 2 | Search window size N; the window spans N+1 bytes |
| pred_rst | output | 1 | Pulse: correct marker seen, clear DC predictors |
| err_unexp | output | 1 | Pulse: marker seen while the interval is 0 |
| err_missing | output | 1 | Pulse: no marker within the search window |
| err_pos | output | 1 | Pulse: marker early or with the wrong index |

## Verification
Two events can land in the same cycle: the `mcu_done` that closes an interval and the byte that completes a marker. The bench sends the marker's 0xFF first. It then drives the final `mcu_done` together with the 0xD0 byte, and in the next interval it drives the final `mcu_done` together with the 0xFF. Both cases must yield a `pred_rst` pulse and no error, which shows that boundary detection and marker recognition are merged correctly rather than one hiding the other.

// File: rtl/rmchk_pkg.sv
package rmchk_pkg;
  typedef enum logic {
    ST_COUNT  = 1'b0,
    ST_SEARCH = 1'b1
  } rm_state_t;

  localparam int unsigned RM_IDX_W = 3;
  localparam logic [7:0]  MK_LEAD  = 8'hFF;
  localparam logic [4:0]  MK_HI    = 5'b11010;
endpackage

// File: rtl/rm_marker_det.sv
module rm_marker_det
  import rmchk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                vld,
  input  logic [DATA_W-1:0]   data,
  output logic                hit,
  output logic [RM_IDX_W-1:0] idx
);
  localparam int unsigned HI_LSB = RM_IDX_W;

  logic lead_seen;

  always_ff @(posedge clk) begin
    if (rst || clr)
      lead_seen <= 1'b0;
    else if (vld)
      lead_seen <= (data == MK_LEAD);
  end

  assign hit = vld && lead_seen && (data[DATA_W-1:HI_LSB] == MK_HI);
  assign idx = data[RM_IDX_W-1:0];
endmodule

// File: rtl/rm_mcu_cnt.sv
module rm_mcu_cnt #(
  parameter int unsigned INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic [INTV_W-1:0] intv,
  output logic              boundary
);
  localparam int unsigned EXT_W = INTV_W + 1;

  logic [INTV_W-1:0] cnt;
  logic [EXT_W-1:0]  cnt_next;

  assign cnt_next = {1'b0, cnt} + EXT_W'(1);
  assign boundary = inc && (intv != '0) && (cnt_next == {1'b0, intv});

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc)
      cnt <= cnt_next[INTV_W-1:0];
  end
endmodule

// File: rtl/rm_window.sv
module rm_window #(
  parameter int unsigned WIN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dec,
  input  logic [WIN_W-1:0] win_sel,
  output logic             empty
);
  localparam int unsigned REM_W = WIN_W + 1;

  logic [REM_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst)
      rem <= '0;
    else if (load)
      rem <= {1'b0, win_sel} + REM_W'(1);
    else if (dec && rem != '0)
      rem <= rem - REM_W'(1);
  end

  assign empty = (rem == '0);
endmodule

// File: rtl/rstmk_checker.sv
module rstmk_checker
  import rmchk_pkg::*;
#(
  parameter int unsigned INTV_W = 16,
  parameter int unsigned WIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_start,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              mcu_done,
  input  logic [INTV_W-1:0] rst_intv,
  input  logic [WIN_W-1:0]  win_sel,
  output logic              pred_rst,
  output logic              err_unexp,
  output logic              err_missing,
  output logic              err_pos
);
  rm_state_t            st;
  logic [RM_IDX_W-1:0]  exp_idx;
  logic                 errored;
  logic                 mk_hit;
  logic [RM_IDX_W-1:0]  mk_idx;
  logic                 boundary;
  logic                 win_empty;
  logic                 cnt_inc, cnt_clr, win_load, win_dec;
  logic                 ev_good, ev_unexp, ev_pos, ev_miss, ev_err;

  rm_marker_det #(.DATA_W(8)) u_det (
    .clk(clk), .rst(rst), .clr(scan_start), .vld(byte_vld),
    .data(byte_data), .hit(mk_hit), .idx(mk_idx)
  );

  rm_mcu_cnt #(.INTV_W(INTV_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .intv(rst_intv), .boundary(boundary)
  );

  rm_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .load(win_load), .dec(win_dec),
    .win_sel(win_sel), .empty(win_empty)
  );

  always_comb begin
    ev_good  = 1'b0;
    ev_unexp = 1'b0;
    ev_pos   = 1'b0;
    ev_miss  = 1'b0;
    win_load = 1'b0;
    win_dec  = 1'b0;
    cnt_inc  = mcu_done && (st == ST_COUNT);
    case (st)
      ST_COUNT: begin
        if (mk_hit) begin
          if (rst_intv == '0)                     ev_unexp = 1'b1;
          else if (boundary && mk_idx == exp_idx) ev_good  = 1'b1;
          else                                    ev_pos   = 1'b1;
        end else if (boundary) begin
          win_load = 1'b1;
        end
      end
      ST_SEARCH: begin
        if (mk_hit) begin
          if (mk_idx == exp_idx) ev_good = 1'b1;
          else                   ev_pos  = 1'b1;
        end else if (byte_vld) begin
          if (win_empty) ev_miss = 1'b1;
          else           win_dec = 1'b1;
        end
      end
      default: ;
    endcase
    ev_err  = ev_unexp | ev_pos | ev_miss;
    cnt_clr = scan_start | ev_good | ev_err;
  end

  always_ff @(posedge clk) begin
    if (rst || scan_start) begin
      st          <= ST_COUNT;
      exp_idx     <= '0;
      errored     <= 1'b0;
      pred_rst    <= 1'b0;
      err_unexp   <= 1'b0;
      err_missing <= 1'b0;
      err_pos     <= 1'b0;
    end else begin
      pred_rst    <= ev_good;
      err_unexp   <= ev_unexp & ~errored;
      err_missing <= ev_miss  & ~errored;
      err_pos     <= ev_pos   & ~errored;
      if (ev_good) begin
        st      <= ST_COUNT;
        exp_idx <= exp_idx + RM_IDX_W'(1);
        errored <= 1'b0;
      end else if (ev_err) begin
        st      <= ST_COUNT;
        errored <= 1'b1;
      end else if (win_load) begin
        st <= ST_SEARCH;
      end
    end
  end
endmodule

// File: rtl/rstmk_checker_sva.sv
module rstmk_checker_sva #(
  parameter int unsigned INTV_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_start,
  input logic              byte_vld,
  input logic [7:0]        byte_data,
  input logic [INTV_W-1:0] rst_intv,
  input logic              pred_rst,
  input logic              err_unexp,
  input logic              err_missing,
  input logic              err_pos
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !(pred_rst || err_unexp || err_missing || err_pos));

  p_good_follows_marker_r2: assert property (@(posedge clk) disable iff (rst)
    pred_rst |-> ($past(byte_vld) && $past(byte_data[7:3]) == 5'b11010));

  p_unexp_zero_intv_r4: assert property (@(posedge clk) disable iff (rst)
    err_unexp |-> ($past(rst_intv) == '0));

  p_pos_on_marker_r5: assert property (@(posedge clk) disable iff (rst)
    err_pos |-> ($past(byte_vld) && $past(byte_data[7:3]) == 5'b11010));

  p_missing_on_byte_r7: assert property (@(posedge clk) disable iff (rst)
    err_missing |-> $past(byte_vld));

  p_single_event_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pred_rst, err_unexp, err_missing, err_pos}));

  p_err_suppressed_r9: assert property (@(posedge clk) disable iff (rst)
    (err_unexp || err_missing || err_pos) |=> !(err_unexp || err_missing || err_pos));

  p_good_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    pred_rst |=> !pred_rst);

  p_scan_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    scan_start |=> !(pred_rst || err_unexp || err_missing || err_pos));
endmodule

bind rstmk_checker rstmk_checker_sva #(.INTV_W(INTV_W)) u_sva (
  .clk(clk), .rst(rst), .scan_start(scan_start), .byte_vld(byte_vld),
  .byte_data(byte_data), .rst_intv(rst_intv), .pred_rst(pred_rst),
  .err_unexp(err_unexp), .err_missing(err_missing), .err_pos(err_pos)
);

// File: tb/rstmk_checker_test.sv
module rstmk_checker_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_start = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        mcu_done = 1'b0;
  logic [15:0] rst_intv = 16'd0;
  logic [1:0]  win_sel = 2'd3;
  logic        pred_rst, err_unexp, err_missing, err_pos;

  int n_chk = 0, n_fail = 0;
  int n_good = 0, n_unx = 0, n_mis = 0, n_pos = 0;
  int b_good, b_unx, b_mis, b_pos;

  always #(CLK_P/2) clk = ~clk;

  rstmk_checker uut (
    .clk(clk), .rst(rst), .scan_start(scan_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .mcu_done(mcu_done), .rst_intv(rst_intv),
    .win_sel(win_sel), .pred_rst(pred_rst), .err_unexp(err_unexp),
    .err_missing(err_missing), .err_pos(err_pos)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (pred_rst)    n_good++;
      if (err_unexp)   n_unx++;
      if (err_missing) n_mis++;
      if (err_pos)     n_pos++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic mark();
    b_good = n_good; b_unx = n_unx; b_mis = n_mis; b_pos = n_pos;
  endtask

  task automatic expect_delta(input string req, input int g, input int u, input int m, input int p);
    chk(req, "pred_rst pulses",    n_good - b_good, g);
    chk(req, "err_unexp pulses",   n_unx - b_unx, u);
    chk(req, "err_missing pulses", n_mis - b_mis, m);
    chk(req, "err_pos pulses",     n_pos - b_pos, p);
  endtask

  task automatic put(input logic [7:0] b);
    byte_vld = 1'b1; byte_data = b; step(); byte_vld = 1'b0;
  endtask

  task automatic mcus(input int n);
    for (int i = 0; i < n; i++) begin
      mcu_done = 1'b1; step(); mcu_done = 1'b0;
    end
  endtask

  task automatic new_scan(input int intv, input int win);
    rst_intv = 16'(intv); win_sel = 2'(win);
    scan_start = 1'b1; step(); scan_start = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R1", "outputs after reset", int'({pred_rst, err_unexp, err_missing, err_pos}), 0);
    rst_intv = 16'd1; win_sel = 2'd3;
    mark(); mcus(1); put(8'hFF); put(8'hD0); step();
    expect_delta("R1", 1, 0, 0, 0);
  endtask

  task automatic t_sequence();
    new_scan(2, 3);
    mark(); mcus(2); put(8'hFF); put(8'hD0); step();
    expect_delta("R3", 1, 0, 0, 0);
    mark(); mcus(2); put(8'hFF); put(8'hFF); put(8'hD1); step();
    expect_delta("R2", 1, 0, 0, 0);
    mark();
    for (int k = 2; k <= 8; k++) begin
      mcus(2); put(8'hFF); put(8'hD0 | 8'(k % 8));
    end
    step();
    expect_delta("R3", 7, 0, 0, 0);
  endtask

  task automatic t_nonmarker();
    new_scan(1, 3);
    mark(); mcus(1); put(8'hFF); put(8'h00); put(8'hFF); put(8'hD8); step();
    expect_delta("R2", 0, 0, 0, 0);
    new_scan(1, 3);
    mark(); mcus(1); put(8'hFF); put(8'hD8); put(8'hFF); put(8'hD0); step();
    expect_delta("R2", 1, 0, 0, 0);
  endtask

  task automatic t_unexp();
    new_scan(0, 3);
    mark(); put(8'hFF); put(8'hD0); step();
    expect_delta("R4", 0, 1, 0, 0);
    mark(); put(8'hFF); put(8'hD1); step();
    expect_delta("R9", 0, 0, 0, 0);
    new_scan(0, 3);
    mark(); put(8'hFF); put(8'hD0); step();
    expect_delta("R10", 0, 1, 0, 0);
  endtask

  task automatic t_early();
    new_scan(3, 3);
    mark(); mcus(1); put(8'hFF); put(8'hD0); step();
    expect_delta("R5", 0, 0, 0, 1);
  endtask

  task automatic t_wrong_idx();
    new_scan(1, 3);
    mark(); mcus(1); put(8'hFF); put(8'hD3); step();
    expect_delta("R6", 0, 0, 0, 1);
  endtask

  task automatic t_window();
    new_scan(1, 0);
    mark(); mcus(1); put(8'h00); step();
    expect_delta("R7", 0, 0, 0, 0);
    put(8'hFF); step();
    expect_delta("R7", 0, 0, 1, 0);
    new_scan(1, 1);
    mark(); mcus(1); put(8'h00); put(8'hFF); put(8'hD0); step();
    expect_delta("R7", 1, 0, 0, 0);
    new_scan(1, 3);
    mark(); mcus(1);
    for (int i = 0; i < 4; i++) put(8'h00);
    step();
    expect_delta("R7", 0, 0, 0, 0);
    put(8'h00); step();
    expect_delta("R7", 0, 0, 1, 0);
  endtask

  task automatic t_same_cycle();
    new_scan(2, 3);
    mark(); mcus(1); put(8'hFF);
    mcu_done = 1'b1; byte_vld = 1'b1; byte_data = 8'hD0; step();
    mcu_done = 1'b0; byte_vld = 1'b0; step();
    expect_delta("R8", 1, 0, 0, 0);
    mark(); mcus(1);
    mcu_done = 1'b1; byte_vld = 1'b1; byte_data = 8'hFF; step();
    mcu_done = 1'b0; byte_vld = 1'b0;
    put(8'hD1); step();
    expect_delta("R8", 1, 0, 0, 0);
  endtask

  task automatic t_mcu_in_search();
    new_scan(1, 3);
    mark(); mcus(1); mcus(3); put(8'hFF); put(8'hD0); step();
    expect_delta("R11", 1, 0, 0, 0);
  endtask

  task automatic t_resync();
    new_scan(1, 0);
    mark(); mcus(1); put(8'h00); put(8'h00); step();
    expect_delta("R9", 0, 0, 1, 0);
    mark(); mcus(1); put(8'hFF); put(8'hD0); step();
    expect_delta("R9", 1, 0, 0, 0);
    mark(); mcus(1); put(8'h00); put(8'h00); step();
    expect_delta("R9", 0, 0, 1, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1", "outputs during reset", int'({pred_rst, err_unexp, err_missing, err_pos}), 0);
    rst = 1'b0;
    step();
    t_reset();
    t_sequence();
    t_nonmarker();
    t_unexp();
    t_early();
    t_wrong_idx();
    t_window();
    t_same_cycle();
    t_mcu_in_search();
    t_resync();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule